// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

A free-running down-counter in a slow timer clock domain produces a periodic one-cycle interrupt pulse. Software programs the interval from a separate bus clock domain. The programmed value crosses into the timer domain through a toggle request and a two-flop synchronizer. The timer domain takes the new value only when it sees the request toggle change. A zero interval keeps the timer idle. Writing a new value restarts the period.

Each interrupt pulse also toggles an event line that is synchronized back into the bus domain, where it sets a sticky flag. The flag holds until software writes a one to clear it.

The first interrupt after a write comes two timer cycles later than the regular period. This extra delay is the cost of bringing the value across the domain boundary. After that first interrupt, the pulses repeat exactly every interval-plus-one timer cycles.

Top module: `wake_tick_timer`

## Requirements
- R1: While the resets are held, and after they are released with no write, `irq_pulse` and `irq_flag` are 0.
- R2: A write of interval 0 stops pulse generation: once it takes effect, `irq_pulse` stays 0 until a nonzero interval takes effect.
- R3: A write is sampled at a bus clock rising edge. It takes effect at the third timer clock rising edge after that bus edge (the load edge). For an effective interval N, the first pulse is high during the timer cycle that follows the (N+3)-th timer edge after the load edge.
- R4: After the first pulse, pulses recur every N+1 timer cycles without drift, for as long as no new write takes effect.
- R5: A written value of 1, 2 or 3 is treated as interval 4. Values of 4 and above are used unchanged.
- R6: A nonzero write that takes effect while the timer is running restarts the timing from its load edge, using the R3 first-pulse latency. A pulse that would fall on the load edge is suppressed.
- R7: Each pulse sets `irq_flag`. The flag reads 1 after the third bus clock rising edge following the timer edge that raised the pulse.
- R8: `clr_flag` high at a bus edge clears `irq_flag` at that edge. If the flag is already 0, the clear leaves it at 0.
- R9: When a flag set and `clr_flag` fall on the same bus edge, the set wins and `irq_flag` reads 1.
- R10: `irq_pulse` is high for exactly one timer clock cycle per interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain synchronous reset, active low |
| wr_en | input | 1 | Interval write strobe |
| wr_data | input | W | Interval value to write |
| clr_flag | input | 1 | Write-one-to-clear for the sticky flag |
| irq_flag | output | 1 | Sticky interrupt flag, bus domain |
| tmr_clk | input | 1 | Timer domain clock |
| tmr_rst_n | input | 1 | Timer domain synchronous reset, active low |
| irq_pulse | output | 1 | One-cycle interrupt pulse, timer domain |

## Verification
Two flag events can fall on the same bus cycle: a flag set arriving from the timer domain and a software clear. To provoke the collision, the bench holds `clr_flag` high over a long window while the timer runs at its minimum interval. That window is certain to span several set edges. A behavioural model predicts the result on every bus and timer cycle, with set taking precedence. A mismatch in the flag on the cycle after a collision shows that the set was lost.

// File: rtl/wake_tick_timer.sv
module wake_tick_timer #(
  parameter int W        = 16,
  parameter int MIN_IVAL = 4
) (
  input  logic         bus_clk,
  input  logic         bus_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_flag,
  output logic         irq_flag,
  input  logic         tmr_clk,
  input  logic         tmr_rst_n,
  output logic         irq_pulse
);
  localparam int CW = W + 1;
  localparam logic [W-1:0] MIN_V = W'(MIN_IVAL);

  logic [W-1:0]  bus_ival;
  logic          req_tgl;
  logic [2:0]    req_s;
  logic          load;
  logic [W-1:0]  t_ival;
  logic          t_run;
  logic [CW-1:0] cnt;
  logic          evt_tgl;
  logic [2:0]    evt_s;
  logic          flag_set;
  logic [W-1:0]  wr_fix;

  assign wr_fix = (wr_data != '0 && wr_data < MIN_V) ? MIN_V : wr_data;

  always_ff @(posedge bus_clk) begin
    if (!bus_rst_n) begin
      bus_ival <= '0;
      req_tgl  <= 1'b0;
    end else if (wr_en) begin
      bus_ival <= wr_fix;
      req_tgl  <= ~req_tgl;
    end
  end

  assign load = req_s[1] ^ req_s[2];

  always_ff @(posedge tmr_clk) begin
    if (!tmr_rst_n) begin
      req_s     <= '0;
      t_ival    <= '0;
      t_run     <= 1'b0;
      cnt       <= '0;
      irq_pulse <= 1'b0;
      evt_tgl   <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_tgl};
      if (load) begin
        t_ival    <= bus_ival;
        t_run     <= bus_ival != '0;
        cnt       <= CW'(bus_ival) + CW'(2);
        irq_pulse <= 1'b0;
      end else if (t_run && cnt == '0) begin
        cnt       <= CW'(t_ival);
        irq_pulse <= 1'b1;
        evt_tgl   <= ~evt_tgl;
      end else begin
        irq_pulse <= 1'b0;
        if (t_run) cnt <= cnt - CW'(1);
      end
    end
  end

  assign flag_set = evt_s[1] ^ evt_s[2];

  always_ff @(posedge bus_clk) begin
    if (!bus_rst_n) begin
      evt_s    <= '0;
      irq_flag <= 1'b0;
    end else begin
      evt_s    <= {evt_s[1:0], evt_tgl};
      irq_flag <= flag_set | (irq_flag & ~clr_flag);
    end
  end
endmodule

// File: rtl/wake_tick_timer_chk.sv
module wake_tick_timer_chk #(
  parameter int W        = 16,
  parameter int MIN_IVAL = 4
) (
  input logic         bus_clk,
  input logic         bus_rst_n,
  input logic         tmr_clk,
  input logic         tmr_rst_n,
  input logic         irq_pulse,
  input logic         irq_flag,
  input logic         clr_flag,
  input logic         flag_set,
  input logic         t_run,
  input logic [W-1:0] t_ival
);
  // R10
  pulse_width_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    irq_pulse |=> !irq_pulse);
  // R2
  idle_quiet_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    !t_run |-> !irq_pulse);
  // R5
  min_ival_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    t_run |-> t_ival >= W'(MIN_IVAL));
  // R7
  flag_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (irq_flag && !clr_flag) |=> irq_flag);
  // R8
  flag_clr_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clr_flag && !flag_set) |=> !irq_flag);
  // R9
  flag_set_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    flag_set |=> irq_flag);
endmodule

bind wake_tick_timer wake_tick_timer_chk #(.W(W), .MIN_IVAL(MIN_IVAL)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
  .irq_pulse(irq_pulse), .irq_flag(irq_flag), .clr_flag(clr_flag),
  .flag_set(flag_set), .t_run(t_run), .t_ival(t_ival)
);

// File: tb/wake_tick_timer_bench.sv
module wake_tick_timer_bench;
  localparam int W = 16;

  logic bus_clk = 1'b0;
  logic tmr_clk = 1'b0;
  logic bus_rst_n = 1'b0;
  logic tmr_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic clr_flag = 1'b0;
  logic irq_flag, irq_pulse;

  wake_tick_timer #(.W(W), .MIN_IVAL(4)) u_wake_tick_timer (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr_flag(clr_flag), .irq_flag(irq_flag), .tmr_clk(tmr_clk),
    .tmr_rst_n(tmr_rst_n), .irq_pulse(irq_pulse));

  always #5 bus_clk = ~bus_clk;
  initial begin
    #27;
    forever begin tmr_clk = 1'b1; #20; tmr_clk = 1'b0; #20; end
  end

  int compared = 0, mismatched = 0;
  bit cmp_on = 0;
  string tag = "R1";

  int tedge = 0, next_p = -1, pend = 0, pval = 0, aval = 0;
  bit exp_pulse = 0, exp_flag = 0;
  int flag_q[$];

  function automatic int fix(input int v);
    return (v == 0) ? 0 : (v < 4 ? 4 : v);
  endfunction

  always @(posedge tmr_clk) begin
    if (!tmr_rst_n) begin
      tedge = 0; next_p = -1; pend = 0; exp_pulse = 0;
    end else begin
      bit ld;
      ld = 0;
      tedge++;
      exp_pulse = 0;
      if (pend > 0) begin
        pend--;
        ld = (pend == 0);
      end
      if (ld) begin
        aval = pval;
        next_p = (aval == 0) ? -1 : tedge + aval + 3;
      end else if (next_p == tedge) begin
        exp_pulse = 1;
        next_p = tedge + aval + 1;
        flag_q.push_back(3);
      end
    end
  end

  always @(posedge bus_clk) begin
    if (!bus_rst_n) begin
      exp_flag = 0;
      flag_q.delete();
    end else begin
      bit set;
      set = 0;
      for (int i = 0; i < flag_q.size(); i++) flag_q[i]--;
      while (flag_q.size() > 0 && flag_q[0] <= 0) begin
        set = 1;
        void'(flag_q.pop_front());
      end
      exp_flag = set | (exp_flag & !clr_flag);
      if (wr_en) begin
        pend = 3;
        pval = fix(int'(wr_data));
      end
    end
  end

  always @(negedge tmr_clk) if (cmp_on) begin
    compared++;
    if (irq_pulse !== exp_pulse) begin
      mismatched++;
      $display("FAIL %s irq_pulse actual=%b expected=%b t=%0t", tag, irq_pulse, exp_pulse, $time);
    end
  end

  always @(negedge bus_clk) if (cmp_on) begin
    compared++;
    if (irq_flag !== exp_flag) begin
      mismatched++;
      $display("FAIL %s irq_flag actual=%b expected=%b t=%0t", tag, irq_flag, exp_flag, $time);
    end
  end

  task automatic wr(input int v);
    @(negedge bus_clk); wr_en = 1'b1; wr_data = W'(v);
    @(negedge bus_clk); wr_en = 1'b0;
  endtask

  task automatic clr(input int n);
    @(negedge bus_clk); clr_flag = 1'b1;
    repeat (n) @(negedge bus_clk);
    clr_flag = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    mismatched++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    #90 cmp_on = 1;
    #10 bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    tag = "R1"; idle(60);
    tag = "R2"; wr(0); idle(120);
    tag = "R3"; wr(10); idle(90);
    tag = "R4"; idle(400);
    tag = "R10"; idle(100);
    tag = "R8"; clr(1); idle(10); clr(1); idle(30);
    tag = "R6"; wr(6); idle(60); wr(9); idle(300);
    tag = "R5"; wr(2); idle(200); wr(1); idle(150); wr(3); idle(150);
    tag = "R9"; clr(200); idle(40);
    tag = "R7"; idle(100);
    tag = "R2"; wr(0); idle(200);
    tag = "R8"; clr(1); idle(20); clr(3); idle(40);
    tag = "R3"; wr(4); idle(200);
    finish_run();
  end
endmodule